// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two predictors and a chooser. The first predictor is a two-level local scheme: the fetch PC selects a per-branch shift register of recent outcomes, and that history selects a 3-bit saturating counter. The second predictor uses a single global outcome history to select a 2-bit counter. The same global history also selects a 2-bit choice counter, and that counter decides which of the two guesses is delivered.

A prediction request carries the fetch PC. The answer comes back combinationally in the same cycle, together with the global history value that produced it. When the request is valid, the predicted direction is shifted into the global history at the next clock edge, which makes the history speculative. The fetch logic keeps the returned history snapshot with the branch and hands it back on the update port when the branch resolves. The update trains the counters and the local history. If the branch was mispredicted, the update also rebuilds the global history from the snapshot and the real outcome.

Top module: `tournament_predictor`

## Requirements
- R1: After synchronous reset, every local history is 0, every 3-bit local counter is 3, every 2-bit global and choice counter is 1, and the global history is 0. As a result every PC is predicted not taken.
- R2: `pred_taken_o` is valid in the same cycle as `pred_pc_i`. It equals the global guess when the MSB of the choice counter is 1, and the local guess when that MSB is 0.
- R3: The local guess is read in two steps. PC bits [11:2] select a 10-bit local history, and that history selects a 3-bit counter. The guess is taken when the counter's MSB is 1.
- R4: The global guess is the MSB of the 2-bit counter that the 12-bit global history selects.
- R5: The choice counter is selected by the same 12-bit global history as the global guess.
- R6: For a valid request that does not coincide with a mispredict update, the global history becomes {history[10:0], predicted bit} at the next edge. `pred_ghist_o` shows the history value from before that shift.
- R7: An update with the mispredict flag set loads the global history with {upd_ghist_i[10:0], upd_taken_i}. This load wins over a shift from a request in the same cycle.
- R8: An update moves two counters one step toward the real outcome: the local counter selected by the branch's current local history, and the global counter selected by `upd_ghist_i`. Both saturate, the local counter at 0 and 7 and the global counter at 0 and 3.
- R9: At update time the local and global guesses are read again, using the branch's local history and `upd_ghist_i`. The choice counter at `upd_ghist_i` changes only if those two guesses differ. It steps up (toward the global side) when the global guess matched the outcome, steps down otherwise, and saturates at 0 and 3.
- R10: An update shifts the real outcome into bit 0 of the branch's local history, which then becomes {history[8:0], outcome}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid_i | input | 1 | A prediction is consumed this cycle, so the global history shifts |
| pred_pc_i | input | 32 | Fetch PC to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_ghist_o | output | 12 | Global history used for this prediction |
| upd_valid_i | input | 1 | A resolved branch update is present |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Real outcome |
| upd_mispred_i | input | 1 | The branch was mispredicted, so the global history is repaired |
| upd_ghist_i | input | 12 | Global history snapshot returned with the branch |

## Verification
On every cycle the assertions check how the global history moves: the speculative shift, the repair on a mispredict and its priority over a same-cycle shift, holding when neither happens, and clearing on reset. They also check that the output follows the two component guesses whenever those guesses agree. Counter saturation, choice training that happens only on disagreement, and the sharing of local counters between branches whose histories are equal are not visible in any single cycle. The bench shows these through predictions that it compares with a reference model after directed and random training sequences.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Which component predictor drives the final answer
    typedef enum logic {
        SEL_LOCAL  = 1'b0,
        SEL_GLOBAL = 1'b1
    } src_sel_e;

    // Training action applied to one saturating counter
    typedef enum logic [1:0] {
        TRN_HOLD = 2'd0,
        TRN_UP   = 2'd1,
        TRN_DOWN = 2'd2
    } trn_e;

    // The two component guesses for one branch
    typedef struct packed {
        logic loc;
        logic glb;
    } vote_t;

    // Direction counters always move toward the real outcome
    function automatic trn_e outcome_step(input logic outcome);
        return outcome ? TRN_UP : TRN_DOWN;
    endfunction

    // Chooser moves only on disagreement, up meaning "trust global"
    function automatic trn_e choice_step(input vote_t v, input logic outcome);
        if (v.loc == v.glb)
            return TRN_HOLD;
        return (v.glb == outcome) ? TRN_UP : TRN_DOWN;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 12,
    parameter int CTR_W = 2
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx_i,
    output logic             look_msb_o,
    input  logic [IDX_W-1:0] trn_idx_i,
    input  trn_e             trn_op_i,
    output logic             trn_msb_o
);
    localparam int               DEPTH    = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_MIN  = '0;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_MAX >> 1;

    logic [CTR_W-1:0] ctr_mem [DEPTH];
    logic [CTR_W-1:0] look_val;
    logic [CTR_W-1:0] cur_val;
    logic [CTR_W-1:0] nxt_val;

    assign look_val   = ctr_mem[look_idx_i];
    assign look_msb_o = look_val[CTR_W-1];
    assign cur_val    = ctr_mem[trn_idx_i];
    assign trn_msb_o  = cur_val[CTR_W-1];

    always_comb begin
        case (trn_op_i)
            TRN_UP:   nxt_val = (cur_val == CTR_MAX) ? cur_val : cur_val + 1'b1;
            TRN_DOWN: nxt_val = (cur_val == CTR_MIN) ? cur_val : cur_val - 1'b1;
            default:  nxt_val = cur_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                ctr_mem[i] <= CTR_INIT;
        end else if (trn_op_i != TRN_HOLD) begin
            ctr_mem[trn_idx_i] <= nxt_val;
        end
    end

endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  look_idx_i,
    output logic [HIST_W-1:0] look_hist_o,
    input  logic [IDX_W-1:0]  upd_idx_i,
    output logic [HIST_W-1:0] upd_hist_o,
    input  logic              upd_en_i,
    input  logic              upd_bit_i
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_mem [DEPTH];

    assign look_hist_o = hist_mem[look_idx_i];
    assign upd_hist_o  = hist_mem[upd_idx_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                hist_mem[i] <= '0;
        end else if (upd_en_i) begin
            hist_mem[upd_idx_i] <= {upd_hist_o[HIST_W-2:0], upd_bit_i};
        end
    end

endmodule

// File: rtl/tp_ghist_reg.sv
module tp_ghist_reg #(
    parameter int GH_W = 12
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            spec_en_i,
    input  logic            spec_bit_i,
    input  logic            fix_en_i,
    input  logic [GH_W-2:0] fix_base_i,
    input  logic            fix_bit_i,
    output logic [GH_W-1:0] ghist_o
);
    logic [GH_W-1:0] gh_q;

    always_ff @(posedge clk) begin
        if (rst)
            gh_q <= '0;
        else if (fix_en_i)
            gh_q <= {fix_base_i, fix_bit_i};
        else if (spec_en_i)
            gh_q <= {gh_q[GH_W-2:0], spec_bit_i};
    end

    assign ghist_o = gh_q;

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10,
    parameter int LCTR_W    = 3,
    parameter int GH_W      = 12,
    parameter int GCTR_W    = 2,
    parameter int CCTR_W    = 2
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            pred_valid_i,
    input  logic [PC_W-1:0] pred_pc_i,
    output logic            pred_taken_o,
    output logic [GH_W-1:0] pred_ghist_o,
    input  logic            upd_valid_i,
    input  logic [PC_W-1:0] upd_pc_i,
    input  logic            upd_taken_i,
    input  logic            upd_mispred_i,
    input  logic [GH_W-1:0] upd_ghist_i
);
    localparam int IDX_HI = PC_LSB + LHT_IDX_W;

    logic [LHT_IDX_W-1:0] pred_lht_idx, upd_lht_idx;
    logic [LHIST_W-1:0]   pred_lhist, upd_lhist;
    logic [GH_W-1:0]      ghist;
    logic                 loc_taken_pred, glb_taken_pred, cho_msb_pred;
    logic                 loc_taken_upd, glb_taken_upd, cho_msb_upd;
    vote_t                upd_vote;
    src_sel_e             pred_sel;
    trn_e                 dir_op, cho_op;
    logic                 repair_en;
    logic                 unused_pc_bits;

    assign pred_lht_idx   = pred_pc_i[PC_LSB +: LHT_IDX_W];
    assign upd_lht_idx    = upd_pc_i[PC_LSB +: LHT_IDX_W];
    assign unused_pc_bits = ^{pred_pc_i[PC_W-1:IDX_HI], pred_pc_i[PC_LSB-1:0],
                              upd_pc_i[PC_W-1:IDX_HI], upd_pc_i[PC_LSB-1:0], cho_msb_upd};

    // Per-branch outcome histories
    tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) lht_i (
        .clk         (clk),
        .rst         (rst),
        .look_idx_i  (pred_lht_idx),
        .look_hist_o (pred_lhist),
        .upd_idx_i   (upd_lht_idx),
        .upd_hist_o  (upd_lhist),
        .upd_en_i    (upd_valid_i),
        .upd_bit_i   (upd_taken_i)
    );

    assign dir_op   = upd_valid_i ? outcome_step(upd_taken_i) : TRN_HOLD;
    assign upd_vote = '{loc: loc_taken_upd, glb: glb_taken_upd};
    assign cho_op   = upd_valid_i ? choice_step(upd_vote, upd_taken_i) : TRN_HOLD;

    // Local counters, selected by local history
    tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) loc_tab_i (
        .clk        (clk),
        .rst        (rst),
        .look_idx_i (pred_lhist),
        .look_msb_o (loc_taken_pred),
        .trn_idx_i  (upd_lhist),
        .trn_op_i   (dir_op),
        .trn_msb_o  (loc_taken_upd)
    );

    // Global counters, selected by global history
    tp_ctr_table #(.IDX_W(GH_W), .CTR_W(GCTR_W)) glb_tab_i (
        .clk        (clk),
        .rst        (rst),
        .look_idx_i (ghist),
        .look_msb_o (glb_taken_pred),
        .trn_idx_i  (upd_ghist_i),
        .trn_op_i   (dir_op),
        .trn_msb_o  (glb_taken_upd)
    );

    // Choice counters, selected by global history
    tp_ctr_table #(.IDX_W(GH_W), .CTR_W(CCTR_W)) cho_tab_i (
        .clk        (clk),
        .rst        (rst),
        .look_idx_i (ghist),
        .look_msb_o (cho_msb_pred),
        .trn_idx_i  (upd_ghist_i),
        .trn_op_i   (cho_op),
        .trn_msb_o  (cho_msb_upd)
    );

    assign pred_sel     = cho_msb_pred ? SEL_GLOBAL : SEL_LOCAL;
    assign pred_taken_o = (pred_sel == SEL_GLOBAL) ? glb_taken_pred : loc_taken_pred;
    assign repair_en    = upd_valid_i && upd_mispred_i;

    tp_ghist_reg #(.GH_W(GH_W)) ghr_i (
        .clk        (clk),
        .rst        (rst),
        .spec_en_i  (pred_valid_i),
        .spec_bit_i (pred_taken_o),
        .fix_en_i   (repair_en),
        .fix_base_i (upd_ghist_i[GH_W-2:0]),
        .fix_bit_i  (upd_taken_i),
        .ghist_o    (ghist)
    );

    assign pred_ghist_o = ghist;

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int GH_W = 12
)(
    input logic            clk,
    input logic            rst,
    input logic            pred_valid_i,
    input logic            pred_taken_o,
    input logic [GH_W-1:0] pred_ghist_o,
    input logic            upd_valid_i,
    input logic            upd_taken_i,
    input logic            upd_mispred_i,
    input logic [GH_W-1:0] upd_ghist_i,
    input logic            loc_guess,
    input logic            glb_guess
);

    p_reset_ghist_r1: assert property (@(posedge clk)
        rst |=> pred_ghist_o == '0);

    p_agree_out_r2: assert property (@(posedge clk) disable iff (rst)
        (loc_guess == glb_guess) |-> (pred_taken_o == loc_guess));

    p_spec_shift_r6: assert property (@(posedge clk) disable iff (rst)
        (pred_valid_i && !(upd_valid_i && upd_mispred_i)) |=>
        pred_ghist_o == {$past(pred_ghist_o[GH_W-2:0]), $past(pred_taken_o)});

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!pred_valid_i && !(upd_valid_i && upd_mispred_i)) |=> $stable(pred_ghist_o));

    p_repair_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_i && upd_mispred_i) |=>
        pred_ghist_o == {$past(upd_ghist_i[GH_W-2:0]), $past(upd_taken_i)});

endmodule

bind tournament_predictor tp_checker #(.GH_W(GH_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .pred_valid_i  (pred_valid_i),
    .pred_taken_o  (pred_taken_o),
    .pred_ghist_o  (pred_ghist_o),
    .upd_valid_i   (upd_valid_i),
    .upd_taken_i   (upd_taken_i),
    .upd_mispred_i (upd_mispred_i),
    .upd_ghist_i   (upd_ghist_i),
    .loc_guess     (loc_taken_pred),
    .glb_guess     (glb_taken_pred)
);

// File: tb/tournament_predictor_tb.sv
`timescale 1ns/1ps
module tournament_predictor_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pred_valid = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken_o;
    logic [11:0] pred_ghist_o;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        upd_mispred = 1'b0;
    logic [11:0] upd_ghist = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_lht [1024];
    int m_loc [1024];
    int m_glb [4096];
    int m_cho [4096];
    int m_gh;
    int last_snap;

    always #5 clk = ~clk;

    tournament_predictor dut_i (
        .clk           (clk),
        .rst           (rst),
        .pred_valid_i  (pred_valid),
        .pred_pc_i     (pred_pc),
        .pred_taken_o  (pred_taken_o),
        .pred_ghist_o  (pred_ghist_o),
        .upd_valid_i   (upd_valid),
        .upd_pc_i      (upd_pc),
        .upd_taken_i   (upd_taken),
        .upd_mispred_i (upd_mispred),
        .upd_ghist_i   (upd_ghist)
    );

    function automatic int pc_idx(input logic [31:0] pc);
        return int'((pc >> 2) & 32'd1023);
    endfunction

    function automatic int sat(input int v, input bit up, input int mx);
        if (up) return (v == mx) ? v : v + 1;
        return (v == 0) ? v : v - 1;
    endfunction

    function automatic bit m_pred(input logic [31:0] pc);
        int lh;
        bit l, g, c;
        lh = m_lht[pc_idx(pc)];
        l  = m_loc[lh] >= 4;
        g  = m_glb[m_gh] >= 2;
        c  = m_cho[m_gh] >= 2;
        return c ? g : l;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 1024; i++) begin
            m_lht[i] = 0;
            m_loc[i] = 3;
        end
        for (int i = 0; i < 4096; i++) begin
            m_glb[i] = 1;
            m_cho[i] = 1;
        end
        m_gh = 0;
        last_snap = 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit pv, input logic [31:0] ppc,
                        input bit uv, input logic [31:0] upc, input bit ut,
                        input bit um, input int ugh);
        bit pt, lt, gt;
        int ui, lh, g;
        g = ugh & 4095;
        @(negedge clk);
        pred_valid  = pv;
        pred_pc     = ppc;
        upd_valid   = uv;
        upd_pc      = upc;
        upd_taken   = ut;
        upd_mispred = um;
        upd_ghist   = g[11:0];
        #1;
        pt = m_pred(ppc);
        check(tag, int'(pred_taken_o), int'(pt));
        check(tag, int'(pred_ghist_o), m_gh);
        if (pv) last_snap = m_gh;
        @(posedge clk);
        if (uv) begin
            ui = pc_idx(upc);
            lh = m_lht[ui];
            lt = m_loc[lh] >= 4;
            gt = m_glb[g] >= 2;
            m_loc[lh] = sat(m_loc[lh], ut, 7);
            m_glb[g]  = sat(m_glb[g], ut, 3);
            if (lt != gt) m_cho[g] = sat(m_cho[g], gt == ut, 3);
            m_lht[ui] = ((lh << 1) | int'(ut)) & 1023;
        end
        if (uv && um)
            m_gh = ((g << 1) | int'(ut)) & 4095;
        else if (pv)
            m_gh = ((m_gh << 1) | int'(pt)) & 4095;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20251));
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, all PCs predict not taken, history zero
        step("R1", 0, 32'h0000_0000, 0, 0, 0, 0, 0);
        step("R1", 0, 32'h0000_0ffc, 0, 0, 0, 0, 0);
        step("R1", 0, 32'h1234_5678, 0, 0, 0, 0, 0);
        step("R1", 0, 32'h0000_1000, 0, 0, 0, 0, 0);

        // R10: local history fills with taken outcomes
        for (int k = 0; k < 14; k++)
            step("R10", 0, 32'h100, 1, 32'h100, 1, 0, 0);
        // R3: prediction now reads the counter at history 0x3FF
        step("R3", 0, 32'h100, 0, 0, 0, 0, 0);
        // R8: a second branch shares the saturated counter at history 0x3FF
        for (int k = 0; k < 14; k++)
            step("R8", 0, 32'h200, 1, 32'h200, 1, 0, 0);
        step("R8", 0, 32'h200, 1, 32'h100, 0, 0, 0);
        step("R8", 0, 32'h200, 0, 0, 0, 0, 0);
        step("R8", 0, 32'h200, 1, 32'h100, 0, 0, 0);
        step("R8", 0, 32'h200, 1, 32'h104, 0, 0, 0);
        step("R8", 0, 32'h200, 0, 0, 0, 0, 0);

        // R7: mispredict repair moves the global history to a new region
        step("R7", 0, 32'h300, 1, 32'h300, 1, 1, 12'h5A5);
        // R4 / R5 / R9: train global and choice counters at that history
        for (int k = 0; k < 6; k++)
            step("R9", 0, 32'h300, 1, 32'h300, 1, 0, 12'hB4B);
        step("R4", 0, 32'h300, 0, 0, 0, 0, 0);
        step("R5", 0, 32'h380, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++)
            step("R9", 0, 32'h380, 1, 32'h380, 0, 0, 12'hB4B);
        step("R9", 0, 32'h380, 0, 0, 0, 0, 0);
        step("R2", 0, 32'h300, 0, 0, 0, 0, 0);

        // R6: speculative shifting over several requests
        for (int k = 0; k < 8; k++)
            step("R6", 1, 32'h300 + 32'(k * 4), 0, 0, 0, 0, 0);
        step("R6", 0, 32'h300, 0, 0, 0, 0, 0);
        // R7: repair wins over a same-cycle request
        step("R7", 1, 32'h300, 1, 32'h300, 0, 1, 12'hFFF);
        step("R7", 1, 32'h300, 1, 32'h300, 1, 1, 12'h801);
        step("R7", 0, 32'h300, 0, 0, 0, 0, 0);

        // R2: random mix against the reference model
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] p, u;
            int sn;
            p  = 32'h400 + 32'(($urandom % 12) * 4);
            u  = 32'h400 + 32'(($urandom % 12) * 4);
            sn = (($urandom % 2) == 0) ? last_snap : int'($urandom % 4096);
            step("R2", ($urandom % 2) == 0, p, ($urandom % 2) == 0, u,
                 ($urandom % 3) != 0, ($urandom % 4) == 0, sn);
        end

        step("R2", 0, 32'h400, 0, 0, 0, 0, 0);
        done = 1;
        finish_run();
    end

endmodule